// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the request and priority core of an eight-line programmable interrupt controller. It keeps three per-line registers: pending requests, lines in service and a line mask. Each request input is captured as either edge or level sensitive. The choice is made per line by a trigger-mode register. Every cycle the block looks for the best unmasked pending request. The search starts from a programmable rotation base. The block raises its interrupt output when that request outranks the highest line currently in service.

A command decoder outside the block drives single-cycle write strobes. These strobes load the mask, the trigger modes, the mode bits and the rotation base, and they retire an in-service line. The interrupt consumer answers with an acknowledge pulse. The acknowledge moves the granted line into service, or retires it at once when automatic end-of-interrupt is on. Inputs and strobes sampled at one clock edge appear on the interrupt output and the grant line one edge later.

Top module: `irq_prio_core`

## Requirements
- R1: After reset, int_o is 0 and grant_line_o is 0. The pending, in-service, mask and trigger-mode registers, the stored previous levels and the rotation base are all cleared, and every line is edge-triggered.
- R2: A line is pending when its request bit is set and its mask bit is clear. Priority index p stands for line (p + base) mod 8, and the smallest pending index wins. While int_o is high, grant_line_o holds the winning line. While int_o is low, grant_line_o is 0.
- R3: int_o is a register. It goes high one cycle after the state it is computed from. It is high only when the winning pending index is strictly smaller than the best index among in-service lines, where an empty in-service set places no bound.
- R4: With mode bit 2 (special mask) set, masked lines are removed from the in-service set before the comparison of R3.
- R5: With mode bit 3 (special nesting) set and the block built as a master, in-service line 2 (the cascade line) is left out of the comparison of R3.
- R6: For a line whose trigger-mode bit is 1, the pending bit copies the input level sampled at each clock edge.
- R7: For a line whose trigger-mode bit is 0, the pending bit is set only when the input is high and the stored previous level is low. It stays set after the input falls. A held-high input does not set it again.
- R8: An acknowledge (ack_i high at an edge while int_o is high) of line L sets in-service bit L when mode bit 0 (automatic end-of-interrupt) is clear. ack_i while int_o is low has no effect.
- R9: With mode bit 0 set, an acknowledge leaves the in-service bits unchanged. If mode bit 1 is also set, the rotation base becomes (L + 1) mod 8.
- R10: An acknowledge clears pending bit L only when line L is edge-triggered. A level-triggered pending bit keeps following its input.
- R11: Trigger-mode writes pass through the parameter TRIG_WMASK, default 8'hFB. Bits outside it stay 0, so with the default, line 2 is always edge-triggered.
- R12: eoi_we_i clears in-service bit eoi_line_i, and base_we_i loads the rotation base from base_wdata_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Request lines |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | New mask, 1 blocks the line |
| trig_we_i | input | 1 | Trigger-mode write strobe |
| trig_wdata_i | input | 8 | New trigger modes, 1 means level |
| mode_we_i | input | 1 | Mode write strobe |
| mode_wdata_i | input | 4 | bit0 auto end-of-interrupt, bit1 rotate on it, bit2 special mask, bit3 special nesting |
| base_we_i | input | 1 | Rotation base write strobe |
| base_wdata_i | input | 3 | New rotation base |
| eoi_we_i | input | 1 | Retire one in-service line |
| eoi_line_i | input | 3 | Line to retire |
| ack_i | input | 1 | Acknowledge of the current grant |
| int_o | output | 1 | Interrupt request to the consumer |
| grant_line_o | output | 3 | Winning line |

## Verification
The assertions assume that ack_i is meant for the grant shown in the same cycle. They also assume that no strobe is held across reset release. The bench drives every strobe and the acknowledge as single-cycle pulses away from the active edge, and it only acknowledges after it has seen int_o high. Edge-triggered requests are raised for one cycle or held, so each rise crosses the stored previous level exactly once. Rotation checks load a new base and a new mask in the same cycle as the request pattern.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    // Mode bits as written on mode_wdata_i (bit 3 down to bit 0)
    typedef struct packed {
        logic spec_nested;
        logic spec_mask;
        logic rot_on_aeoi;
        logic auto_eoi;
    } irq_mode_t;
endpackage

// File: rtl/irq_prio_search.sv
// Rotated lowest-index search over a line vector.
module irq_prio_search #(
    parameter int unsigned N_LINES = 8,
    localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] vec_i,
    input  logic [IDX_W-1:0]   base_i,
    output logic [IDX_W:0]     rank_o,   // N_LINES when vec_i is empty
    output logic [IDX_W-1:0]   line_o
);
    logic [IDX_W-1:0] cand;

    always_comb begin
        rank_o = (IDX_W+1)'(N_LINES);
        line_o = '0;
        cand   = '0;
        for (int p = N_LINES - 1; p >= 0; p--) begin
            cand = IDX_W'(p) + base_i;
            if (vec_i[cand]) begin
                rank_o = (IDX_W+1)'(p);
                line_o = cand;
            end
        end
    end
endmodule

// File: rtl/irq_req_capture.sv
// Request register, stored previous levels and trigger modes.
module irq_req_capture #(
    parameter int unsigned          N_LINES    = 8,
    parameter logic [N_LINES-1:0]   TRIG_WMASK = 8'hFB,
    localparam int unsigned         IDX_W      = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    input  logic               trig_we_i,
    input  logic [N_LINES-1:0] trig_wdata_i,
    input  logic               clr_en_i,
    input  logic [IDX_W-1:0]   clr_line_i,
    output logic [N_LINES-1:0] irr_o
);
    typedef struct packed {
        logic [N_LINES-1:0] irr;
        logic [N_LINES-1:0] prev;
        logic [N_LINES-1:0] trig;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_we_i) begin
            st_d.trig = trig_wdata_i & TRIG_WMASK;
        end
        for (int i = 0; i < N_LINES; i++) begin
            if (clr_en_i && (clr_line_i == IDX_W'(i)) && !st_q.trig[i]) begin
                st_d.irr[i] = 1'b0;
            end
            if (st_q.trig[i]) begin
                st_d.irr[i] = req_i[i];
            end else if (req_i[i] && !st_q.prev[i]) begin
                st_d.irr[i] = 1'b1;
            end
            st_d.prev[i] = req_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irr_o = st_q.irr;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line_chk
        // R6: level lines copy the sampled input
        p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(st_q.trig[g]) |-> (st_q.irr[g] == $past(req_i[g])));
        // R7: an edge line only rises on a fresh rising input
        p_edge_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(st_q.irr[g]) && !$past(st_q.trig[g])) |-> $past(req_i[g] && !st_q.prev[g]));
        // R11: bits outside the writable set never become level
        p_trig_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !TRIG_WMASK[g] |-> !st_q.trig[g]);
    end
endmodule

// File: rtl/irq_service_ctl.sv
// In-service register, rotation base, INT decision and acknowledge handling.
module irq_service_ctl
    import irq_prio_pkg::*;
#(
    parameter int unsigned N_LINES      = 8,
    parameter bit          IS_MASTER    = 1'b1,
    parameter int unsigned CASCADE_LINE = 2,
    localparam int unsigned IDX_W       = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irr_i,
    input  logic [N_LINES-1:0] imr_i,
    input  irq_mode_t          mode_i,
    input  logic               ack_i,
    input  logic               base_we_i,
    input  logic [IDX_W-1:0]   base_wdata_i,
    input  logic               eoi_we_i,
    input  logic [IDX_W-1:0]   eoi_line_i,
    output logic               int_o,
    output logic [IDX_W-1:0]   line_o
);
    typedef struct packed {
        logic [N_LINES-1:0] isr;
        logic [IDX_W-1:0]   rot;
        logic               int_r;
        logic [IDX_W-1:0]   line;
    } svc_state_t;

    svc_state_t st_d, st_q;

    logic [N_LINES-1:0] pend_vec, isr_view;
    logic [IDX_W:0]     pend_rank, svc_rank;
    logic [IDX_W-1:0]   pend_line, svc_line;
    logic               take;

    always_comb begin
        pend_vec = irr_i & ~imr_i;
        isr_view = st_q.isr;
        if (mode_i.spec_mask) begin
            isr_view = isr_view & ~imr_i;
        end
        if (IS_MASTER && mode_i.spec_nested) begin
            isr_view[CASCADE_LINE] = 1'b0;
        end
    end

    irq_prio_search #(.N_LINES(N_LINES)) u_pend_search (
        .vec_i  (pend_vec),
        .base_i (st_q.rot),
        .rank_o (pend_rank),
        .line_o (pend_line)
    );

    irq_prio_search #(.N_LINES(N_LINES)) u_svc_search (
        .vec_i  (isr_view),
        .base_i (st_q.rot),
        .rank_o (svc_rank),
        .line_o (svc_line)
    );

    assign take = ack_i && st_q.int_r;

    always_comb begin
        st_d       = st_q;
        st_d.int_r = (pend_rank < svc_rank);
        st_d.line  = st_d.int_r ? pend_line : '0;
        if (base_we_i) begin
            st_d.rot = base_wdata_i;
        end
        if (take) begin
            if (mode_i.auto_eoi) begin
                if (mode_i.rot_on_aeoi) begin
                    st_d.rot = st_q.line + 1'b1;
                end
            end else begin
                st_d.isr[st_q.line] = 1'b1;
            end
        end
        if (eoi_we_i) begin
            st_d.isr[eoi_line_i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_o  = st_q.int_r;
    assign line_o = st_q.line;

    logic unused_svc;
    assign unused_svc = ^svc_line;

    // R8: a plain acknowledge puts the granted line in service
    p_ack_isr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !mode_i.auto_eoi && !eoi_we_i) |=> st_q.isr[$past(st_q.line)]);
    // R8: acknowledge without a grant leaves service state alone
    p_ack_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !st_q.int_r && !eoi_we_i) |=> $stable(st_q.isr));
    // R9: automatic end-of-interrupt never fills the in-service set
    p_aeoi_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode_i.auto_eoi && !eoi_we_i) |=> $stable(st_q.isr));
    // R9: rotation follows the retired line
    p_aeoi_rot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode_i.auto_eoi && mode_i.rot_on_aeoi) |=> (st_q.rot == IDX_W'($past(st_q.line) + 1'b1)));
    // R2: grant line is 0 while INT is low
    p_idle_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !int_o |-> (line_o == '0));
endmodule

// File: rtl/irq_prio_core.sv
// Top: mask and mode registers plus the capture and service stages.
module irq_prio_core
    import irq_prio_pkg::*;
#(
    parameter int unsigned          N_LINES      = 8,
    parameter logic [N_LINES-1:0]   TRIG_WMASK   = 8'hFB,
    parameter bit                   IS_MASTER    = 1'b1,
    parameter int unsigned          CASCADE_LINE = 2,
    localparam int unsigned         IDX_W        = $clog2(N_LINES),
    localparam int unsigned         MODE_W       = $bits(irq_mode_t)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    input  logic               mask_we_i,
    input  logic [N_LINES-1:0] mask_wdata_i,
    input  logic               trig_we_i,
    input  logic [N_LINES-1:0] trig_wdata_i,
    input  logic               mode_we_i,
    input  logic [MODE_W-1:0]  mode_wdata_i,
    input  logic               base_we_i,
    input  logic [IDX_W-1:0]   base_wdata_i,
    input  logic               eoi_we_i,
    input  logic [IDX_W-1:0]   eoi_line_i,
    input  logic               ack_i,
    output logic               int_o,
    output logic [IDX_W-1:0]   grant_line_o
);
    typedef struct packed {
        logic [N_LINES-1:0] imr;
        irq_mode_t          mode;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;
    logic [N_LINES-1:0] irr_w;

    always_comb begin
        cfg_d = cfg_q;
        if (mask_we_i) begin
            cfg_d.imr = mask_wdata_i;
        end
        if (mode_we_i) begin
            cfg_d.mode = irq_mode_t'(mode_wdata_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    irq_req_capture #(
        .N_LINES    (N_LINES),
        .TRIG_WMASK (TRIG_WMASK)
    ) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .trig_we_i    (trig_we_i),
        .trig_wdata_i (trig_wdata_i),
        .clr_en_i     (ack_i && int_o),
        .clr_line_i   (grant_line_o),
        .irr_o        (irr_w)
    );

    irq_service_ctl #(
        .N_LINES      (N_LINES),
        .IS_MASTER    (IS_MASTER),
        .CASCADE_LINE (CASCADE_LINE)
    ) u_service (
        .clk          (clk),
        .rst_n        (rst_n),
        .irr_i        (irr_w),
        .imr_i        (cfg_q.imr),
        .mode_i       (cfg_q.mode),
        .ack_i        (ack_i),
        .base_we_i    (base_we_i),
        .base_wdata_i (base_wdata_i),
        .eoi_we_i     (eoi_we_i),
        .eoi_line_i   (eoi_line_i),
        .int_o        (int_o),
        .line_o       (grant_line_o)
    );

    // R2: a granted line was pending and unmasked one cycle earlier
    p_grant_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((($past(irr_w) & ~$past(cfg_q.imr)) & (N_LINES'(1) << grant_line_o)) != '0));
    // R3: with nothing pending there is no interrupt on the next cycle
    p_no_pend_no_int_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr_w & ~cfg_q.imr) == '0) |=> !int_o);
endmodule

// File: tb/irq_prio_core_tb.sv
module irq_prio_core_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_i, mask_wdata_i, trig_wdata_i;
    logic       mask_we_i, trig_we_i, mode_we_i, base_we_i, eoi_we_i, ack_i;
    logic [3:0] mode_wdata_i;
    logic [2:0] base_wdata_i, eoi_line_i, grant_line_o;
    logic       int_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irq_prio_core u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
        .trig_we_i(trig_we_i), .trig_wdata_i(trig_wdata_i),
        .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i),
        .base_we_i(base_we_i), .base_wdata_i(base_wdata_i),
        .eoi_we_i(eoi_we_i), .eoi_line_i(eoi_line_i),
        .ack_i(ack_i), .int_o(int_o), .grant_line_o(grant_line_o)
    );

    typedef struct packed {
        logic [2:0] base;
        logic [7:0] mask;
        logic [7:0] req;
        logic       e_int;
        logic [2:0] e_line;
    } vec_t;

    // all lines level-triggered, line 2 never requested
    localparam vec_t VECS [10] = '{
        '{3'd0, 8'h00, 8'h00, 1'b0, 3'd0},
        '{3'd0, 8'h00, 8'h88, 1'b1, 3'd3},
        '{3'd4, 8'h00, 8'h88, 1'b1, 3'd7},
        '{3'd4, 8'h80, 8'h88, 1'b1, 3'd3},
        '{3'd0, 8'hFF, 8'hFB, 1'b0, 3'd0},
        '{3'd7, 8'h00, 8'h03, 1'b1, 3'd0},
        '{3'd1, 8'h00, 8'h03, 1'b1, 3'd1},
        '{3'd6, 8'h01, 8'h43, 1'b1, 3'd6},
        '{3'd5, 8'h40, 8'h43, 1'b1, 3'd0},
        '{3'd3, 8'h00, 8'h10, 1'b1, 3'd4}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input logic e_int, input logic [2:0] e_line);
        chk({tag, " int"}, {7'd0, int_o}, {7'd0, e_int});
        chk({tag, " line"}, {5'd0, grant_line_o}, {5'd0, e_line});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_i = '0; mask_we_i = 0; mask_wdata_i = '0; trig_we_i = 0; trig_wdata_i = '0;
        mode_we_i = 0; mode_wdata_i = '0; base_we_i = 0; base_wdata_i = '0;
        eoi_we_i = 0; eoi_line_i = '0; ack_i = 0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic pulse_req(input logic [7:0] m);
        req_i = req_i | m; tick(1); req_i = req_i & ~m; tick(3);
    endtask
    task automatic do_ack();
        ack_i = 1'b1; tick(1); ack_i = 1'b0; tick(3);
    endtask
    task automatic set_mode(input logic [3:0] m);
        mode_we_i = 1'b1; mode_wdata_i = m; tick(1); mode_we_i = 1'b0; tick(3);
    endtask
    task automatic set_trig(input logic [7:0] t);
        trig_we_i = 1'b1; trig_wdata_i = t; tick(1); trig_we_i = 1'b0; tick(3);
    endtask
    task automatic set_mask(input logic [7:0] m);
        mask_we_i = 1'b1; mask_wdata_i = m; tick(1); mask_we_i = 1'b0; tick(3);
    endtask
    task automatic do_eoi(input logic [2:0] l);
        eoi_we_i = 1'b1; eoi_line_i = l; tick(1); eoi_we_i = 1'b0; tick(3);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk_out("R1 reset", 1'b0, 3'd0);

        // R2 R3 R6 R12: table of rotation base, mask and level requests
        set_trig(8'hFF);
        foreach (VECS[k]) begin
            base_we_i = 1'b1; base_wdata_i = VECS[k].base;
            mask_we_i = 1'b1; mask_wdata_i = VECS[k].mask;
            req_i     = VECS[k].req;
            tick(1);
            base_we_i = 1'b0; mask_we_i = 1'b0;
            tick(3);
            chk_out($sformatf("R2 R12 vec%0d", k), VECS[k].e_int, VECS[k].e_line);
        end

        // R7 R9 R10: held edge request under auto end-of-interrupt
        do_reset();
        set_mode(4'h1);
        req_i = 8'h20; tick(3);
        chk_out("R7 edge held", 1'b1, 3'd5);
        do_ack();
        chk_out("R10 edge cleared, R7 no re-trigger", 1'b0, 3'd0);
        req_i = 8'h00; tick(1); req_i = 8'h20; tick(3);
        chk_out("R9 no isr after aeoi", 1'b1, 3'd5);

        // R6 R10: level line survives acknowledge
        do_reset();
        set_mode(4'h1);
        set_trig(8'h10);
        req_i = 8'h10; tick(3);
        chk_out("R6 level set", 1'b1, 3'd4);
        do_ack();
        chk_out("R10 level kept", 1'b1, 3'd4);
        req_i = 8'h00; tick(3);
        chk_out("R6 level drop", 1'b0, 3'd0);

        // R3 R8 R12: nesting against in-service lines
        do_reset();
        pulse_req(8'h20);
        chk_out("R7 edge pulse", 1'b1, 3'd5);
        do_ack();
        chk_out("R8 in service blocks", 1'b0, 3'd0);
        pulse_req(8'h40);
        chk_out("R3 lower blocked", 1'b0, 3'd0);
        do_ack();
        do_eoi(3'd5);
        chk_out("R8 idle ack ignored, R12 eoi", 1'b1, 3'd6);
        do_ack();
        chk_out("R8 line6 in service", 1'b0, 3'd0);
        pulse_req(8'h02);
        chk_out("R3 higher outranks", 1'b1, 3'd1);

        // R4 special mask
        do_reset();
        pulse_req(8'h20);
        do_ack();
        pulse_req(8'h40);
        chk_out("R4 before special mask", 1'b0, 3'd0);
        set_mask(8'h20);
        set_mode(4'h4);
        chk_out("R4 special mask", 1'b1, 3'd6);
        set_mode(4'h0);
        chk_out("R4 special mask off", 1'b0, 3'd0);

        // R5 special nesting on the cascade line
        do_reset();
        pulse_req(8'h04);
        chk_out("R5 cascade pending", 1'b1, 3'd2);
        do_ack();
        pulse_req(8'h04);
        chk_out("R5 nesting off", 1'b0, 3'd0);
        set_mode(4'h8);
        chk_out("R5 nesting on", 1'b1, 3'd2);

        // R9 rotate on auto end-of-interrupt
        do_reset();
        set_mode(4'h3);
        pulse_req(8'h08);
        chk_out("R9 grant before rotate", 1'b1, 3'd3);
        do_ack();
        pulse_req(8'h24);
        chk_out("R9 rotated base", 1'b1, 3'd5);

        // R11 trigger write mask keeps line 2 edge-triggered
        do_reset();
        set_trig(8'hFF);
        req_i = 8'h04; tick(3);
        req_i = 8'h00; tick(3);
        chk_out("R11 line2 stays edge", 1'b1, 3'd2);
        req_i = 8'h80; tick(3);
        set_mask(8'h04);
        req_i = 8'h00; tick(3);
        chk_out("R11 line7 is level", 1'b0, 3'd0);

        done = 1'b1;
        finish_run();
    end
endmodule